// File: doc/BRIEF.md
# Frequency Lock and Link-Fault Detector

This block decides whether a clock recovery loop is running at the right frequency. It counts strobes from the recovered clock over a measurement window of a fixed number of reference-clock strobes. Both strobes arrive already synchronized to one fast system clock. The window's recovered count is compared with the reference count times a ratio chosen by a two-bit code. When the count falls within a symmetric tolerance of roughly 1000 ppm, the block raises its lock indicator. When it does not, the block steers the recovery loop to train on the reference-derived frequency. Measurement windows keep running back to back, so lock is regained as soon as one window passes.

A carrier-detect input overrides the count results. While carrier is absent, the retimed data is gated low, the lock indicator is held low and the loop is held in reference training. Any change of the ratio code abandons the window in progress. The block also passes a clock-select input through as the transmit-clock source select.

Top module: `fld_lock_detect`

## Requirements
- R1: The ratio code `ratioSel` selects the expected recovered-to-reference ratio: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 16 and 2'b11 gives 20. A window spans 2**WIN_LOG2 reference strobes, and the expected recovered count is the ratio times that number.
- R2: A window passes when the recovered count differs from the expected count by no more than the tolerance. The tolerance is the expected count shifted right by TOL_SHIFT, with a minimum of 1. The result takes effect at the clock edge that samples the window-closing reference strobe.
- R3: A window whose count lies outside the tolerance clears lock. This holds for counts above the expected value and for counts below it.
- R4: Windows repeat without gaps. After a failing window, the next passing window sets lock again.
- R5: `linkUp` is high only while `carrierOk` is high and the last completed window passed. `trainOnRef` is always the inverse of `linkUp`.
- R6: While `carrierOk` is low, `dataForceLow` is high, `linkUp` is low and `trainOnRef` is high, in the same cycle and whatever the counts. Lock is cleared, and a fresh window starts once carrier returns.
- R7: A change of `ratioSel` abandons the window in progress and clears lock. A complete new window must pass before lock is declared again.
- R8: `txUseRecovered` follows the `txClkSel` input: high selects the recovered clock and low selects the synthesizer clock.
- R9: After synchronous active-low reset, `linkUp` is low, `trainOnRef` is high, and the first window begins with both counters at zero.
- R10: The recovered counter saturates at its maximum instead of wrapping. A grossly overspeed input therefore fails, even when the wrapped count would fall inside the tolerance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Synchronous active-low reset |
| refTick | input | 1 | One-cycle strobe per reference clock cycle |
| recTick | input | 1 | One-cycle strobe per recovered clock cycle |
| carrierOk | input | 1 | Carrier present |
| ratioSel | input | 2 | Expected frequency ratio code |
| txClkSel | input | 1 | Transmit clock source choice |
| linkUp | output | 1 | Lock indicator, low on link fault |
| trainOnRef | output | 1 | Steers the recovery loop onto the reference frequency |
| dataForceLow | output | 1 | Gates retimed data low |
| txUseRecovered | output | 1 | Transmit clock source select |

## Verification
The bench builds the block with WIN_LOG2 = 6 and TOL_SHIFT = 6, which gives 64-strobe windows and tolerances of 8 to 20 counts. With these values a whole window costs at most about 1400 cycles, so dozens of windows fit in the run. The bench can place counts exactly on the tolerance edge and one count past it for every ratio code. The recovered counter is 12 bits wide, so an overspeed count whose wrapped value lands inside the tolerance is cheap to produce, and it shows whether the counter saturates.

// File: rtl/fld_pkg.sv
package fld_pkg;

  // control to datapath strobes
  typedef struct packed {
    logic       clearCnt;
    logic [1:0] ratioCode;
  } fld_ctrl_t;

  // datapath to control status
  typedef struct packed {
    logic winDone;
    logic inTol;
  } fld_stat_t;

  function automatic logic [4:0] ratioOf(input logic [1:0] code);
    case (code)
      2'b00:   return 5'd8;
      2'b01:   return 5'd10;
      2'b10:   return 5'd16;
      default: return 5'd20;
    endcase
  endfunction

endpackage

// File: rtl/fld_datapath.sv
module fld_datapath
  import fld_pkg::*;
#(
  parameter int WIN_LOG2  = 10,
  parameter int TOL_SHIFT = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      refTick,
  input  logic      recTick,
  input  fld_ctrl_t ctrlBus,
  output fld_stat_t statBus
);
  localparam int REF_W = WIN_LOG2;
  localparam int CNT_W = WIN_LOG2 + 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [REF_W-1:0] REF_LAST = '1;

  logic [REF_W-1:0] refCnt;
  logic [CNT_W-1:0] recCnt;
  logic [CNT_W-1:0] recSum;
  logic [CNT_W-1:0] expCnt;
  logic [CNT_W-1:0] tolRaw;
  logic [CNT_W-1:0] tolCnt;
  logic [CNT_W-1:0] diffCnt;
  logic             refLast;

  // saturating count including this cycle's strobe
  always_comb begin
    if (recTick && (recCnt != CNT_MAX)) recSum = recCnt + 1'b1;
    else                                recSum = recCnt;
  end

  always_comb begin
    expCnt  = CNT_W'(ratioOf(ctrlBus.ratioCode)) << WIN_LOG2;
    tolRaw  = expCnt >> TOL_SHIFT;
    tolCnt  = (tolRaw == '0) ? CNT_W'(1) : tolRaw;
    diffCnt = (recSum >= expCnt) ? (recSum - expCnt) : (expCnt - recSum);
  end

  assign refLast         = refTick && (refCnt == REF_LAST);
  assign statBus.winDone = refLast && !ctrlBus.clearCnt;
  assign statBus.inTol   = (diffCnt <= tolCnt);

  always_ff @(posedge clk) begin
    if (!rstN || ctrlBus.clearCnt || refLast) begin
      refCnt <= '0;
      recCnt <= '0;
    end else begin
      refCnt <= refCnt + REF_W'(refTick);
      recCnt <= recSum;
    end
  end

endmodule

// File: rtl/fld_control.sv
module fld_control
  import fld_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierOk,
  input  logic [1:0] ratioSel,
  input  fld_stat_t  statBus,
  output fld_ctrl_t  ctrlBus,
  output logic       linkUp,
  output logic       trainOnRef,
  output logic       dataForceLow
);
  logic [1:0] ratioReg;
  logic       lockReg;
  logic       abortWin;

  assign abortWin = !carrierOk || (ratioSel != ratioReg);

  always_ff @(posedge clk) begin
    ratioReg <= ratioSel;
    if (!rstN) begin
      lockReg <= 1'b0;
    end else if (abortWin) begin
      lockReg <= 1'b0;
    end else if (statBus.winDone) begin
      lockReg <= statBus.inTol;
    end
  end

  assign ctrlBus.clearCnt  = abortWin;
  assign ctrlBus.ratioCode = ratioReg;

  assign linkUp       = lockReg && carrierOk;
  assign trainOnRef   = !linkUp;
  assign dataForceLow = !carrierOk;

endmodule

// File: rtl/fld_lock_detect.sv
module fld_lock_detect
  import fld_pkg::*;
#(
  parameter int WIN_LOG2  = 10,
  parameter int TOL_SHIFT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       recTick,
  input  logic       carrierOk,
  input  logic [1:0] ratioSel,
  input  logic       txClkSel,
  output logic       linkUp,
  output logic       trainOnRef,
  output logic       dataForceLow,
  output logic       txUseRecovered
);
  fld_ctrl_t ctrlBus;
  fld_stat_t statBus;

  fld_datapath #(
    .WIN_LOG2 (WIN_LOG2),
    .TOL_SHIFT(TOL_SHIFT)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .refTick(refTick),
    .recTick(recTick),
    .ctrlBus(ctrlBus),
    .statBus(statBus)
  );

  fld_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .carrierOk   (carrierOk),
    .ratioSel    (ratioSel),
    .statBus     (statBus),
    .ctrlBus     (ctrlBus),
    .linkUp      (linkUp),
    .trainOnRef  (trainOnRef),
    .dataForceLow(dataForceLow)
  );

  assign txUseRecovered = txClkSel;

endmodule

// File: rtl/fld_lock_checker.sv
module fld_lock_checker (
  input logic       clk,
  input logic       rstN,
  input logic       carrierOk,
  input logic [1:0] ratioSel,
  input logic       linkUp,
  input logic       trainOnRef,
  input logic       dataForceLow,
  input logic       winDone,
  input logic       inTol
);

  assert_rise_needs_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> $past(winDone && inTol));

  assert_fail_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (winDone && !inTol) |=> !linkUp);

  assert_pass_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (winDone && inTol && carrierOk) |=> (linkUp || !carrierOk));

  assert_link_needs_carrier_R5: assert property (@(posedge clk) disable iff (!rstN)
    linkUp |-> (carrierOk && !trainOnRef));

  assert_no_carrier_forces_R6: assert property (@(posedge clk) disable iff (!rstN)
    !carrierOk |-> (dataForceLow && trainOnRef && !linkUp));

  assert_ratio_change_drops_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ratioSel != $past(ratioSel)) |=> !linkUp);

endmodule

bind fld_lock_detect fld_lock_checker u_fld_chk (
  .clk         (clk),
  .rstN        (rstN),
  .carrierOk   (carrierOk),
  .ratioSel    (ratioSel),
  .linkUp      (linkUp),
  .trainOnRef  (trainOnRef),
  .dataForceLow(dataForceLow),
  .winDone     (statBus.winDone),
  .inTol       (statBus.inTol)
);

// File: tb/test_fld_lock_detect.sv
module test_fld_lock_detect;
  localparam int WIN_LOG2  = 6;
  localparam int TOL_SHIFT = 6;
  localparam int WIN       = 1 << WIN_LOG2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refTick = 1'b0;
  logic       recTick = 1'b0;
  logic       carrierOk = 1'b1;
  logic [1:0] ratioSel = 2'b00;
  logic       txClkSel = 1'b0;
  logic       linkUp, trainOnRef, dataForceLow, txUseRecovered;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit expLock = 1'b0;

  always #5 clk = ~clk;

  fld_lock_detect #(.WIN_LOG2(WIN_LOG2), .TOL_SHIFT(TOL_SHIFT)) i_fld_lock_detect (
    .clk(clk), .rstN(rstN), .refTick(refTick), .recTick(recTick),
    .carrierOk(carrierOk), .ratioSel(ratioSel), .txClkSel(txClkSel),
    .linkUp(linkUp), .trainOnRef(trainOnRef), .dataForceLow(dataForceLow),
    .txUseRecovered(txUseRecovered)
  );

  function automatic int ratioVal(input logic [1:0] c);
    case (c)
      2'b00: return 8;
      2'b01: return 10;
      2'b10: return 16;
      default: return 20;
    endcase
  endfunction

  function automatic int expCount(input logic [1:0] c);
    return ratioVal(c) * WIN;
  endfunction

  function automatic int tolOf(input logic [1:0] c);
    int t;
    t = expCount(c) >> TOL_SHIFT;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic bit passes(input logic [1:0] c, input int n);
    int d;
    d = n - expCount(c);
    if (d < 0) d = -d;
    if (n > 4095) return 1'b0;  // R10: saturated counter cannot match
    return d <= tolOf(c);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic c);
    @(negedge clk);
    refTick = r;
    recTick = c;
  endtask

  // run nRef reference periods carrying recN recovered strobes, closing the window if nRef == WIN
  task automatic runPeriods(input int nRef, input int recN);
    for (int i = 0; i < nRef; i++) begin
      int k;
      k = recN / nRef + ((i < recN % nRef) ? 1 : 0);
      for (int j = 0; j < k; j++) cyc(1'b0, 1'b1);
      cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
    end
    cyc(1'b0, 1'b0);
  endtask

  task automatic runWindow(input int recN, input string req);
    runPeriods(WIN, recN);
    expLock = passes(ratioSel, recN);
    check(linkUp == expLock, req, linkUp, expLock);
    check(trainOnRef == !expLock, req, trainOnRef, !expLock);
  endtask

  task automatic changeRatio(input logic [1:0] c);
    @(negedge clk);
    ratioSel = c;
    @(negedge clk);
    expLock = 1'b0;
    check(linkUp == 1'b0, "R7 ratio change clears lock", linkUp, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: reset state
    check(linkUp == 1'b0, "R9 reset linkUp", linkUp, 0);
    check(trainOnRef == 1'b1, "R9 reset trainOnRef", trainOnRef, 1);
    @(negedge clk);
    rstN = 1'b1;

    // R8 clock select pass-through
    txClkSel = 1'b1; #1;
    check(txUseRecovered == 1'b1, "R8 select recovered", txUseRecovered, 1);
    txClkSel = 1'b0; #1;
    check(txUseRecovered == 1'b0, "R8 select synth", txUseRecovered, 0);

    // R1 R2: exact and edge counts for every ratio code
    for (int c = 0; c < 4; c++) begin
      if (c != 0) changeRatio(2'(c));
      runWindow(expCount(2'(c)), "R1 exact count locks");
      runWindow(expCount(2'(c)) + tolOf(2'(c)), "R2 upper edge passes");
      runWindow(expCount(2'(c)) + tolOf(2'(c)) + 1, "R3 above tolerance fails");
      runWindow(expCount(2'(c)) - tolOf(2'(c)), "R4 repoll relocks at lower edge");
      runWindow(expCount(2'(c)) - tolOf(2'(c)) - 1, "R3 below tolerance fails");
    end

    // R4: fail then pass relocks
    runWindow(expCount(ratioSel) + 3 * tolOf(ratioSel), "R3 far above fails");
    runWindow(expCount(ratioSel) - 1, "R4 relock after fault");

    // R6: carrier override
    @(negedge clk);
    carrierOk = 1'b0; #1;
    check(linkUp == 1'b0, "R6 carrier low linkUp", linkUp, 0);
    check(trainOnRef == 1'b1, "R6 carrier low trains", trainOnRef, 1);
    check(dataForceLow == 1'b1, "R6 carrier low data gate", dataForceLow, 1);
    runPeriods(10, expCount(ratioSel) / 6);
    check(linkUp == 1'b0, "R6 counts ignored without carrier", linkUp, 0);
    carrierOk = 1'b1; #1;
    check(dataForceLow == 1'b0, "R6 data gate released", dataForceLow, 0);
    check(linkUp == 1'b0, "R6 lock cleared after carrier loss", linkUp, 0);
    runWindow(expCount(ratioSel), "R6 fresh window after carrier");

    // R7: partial window then ratio change needs full fresh window
    changeRatio(2'b00);
    runPeriods(40, 40 * 8);
    changeRatio(2'b01);
    runWindow(expCount(2'b01), "R7 full fresh window relocks");

    // R10: overspeed whose wrapped count would pass
    changeRatio(2'b00);
    runWindow(512, "R1 relock ratio 8");
    runWindow(4096 + 512, "R10 saturation fails overspeed");

    // random windows
    for (int n = 0; n < 14; n++) begin
      logic [1:0] c;
      int t, off;
      c = 2'($urandom % 4);
      if (c != ratioSel) changeRatio(c);
      t = tolOf(c);
      off = int'($urandom % (4 * t + 1)) - 2 * t;
      runWindow(expCount(c) + off, "R2 random window");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule